// File: doc/BRIEF.md
# Memory Pattern Fill Engine

This block writes one repeating 32-bit word across a region of local memory. Software sets up three configuration registers over a 32-bit register bus: a byte offset where the region starts, its length in bytes, and the fill word. It then writes a separate start register. On that write the engine copies the three values into its own working registers. It then issues one 32-bit write per word through a memory write port that uses a valid/ready handshake. The address starts at the offset and rises by 4 for each word.

When the last word has been accepted, the engine sets its own completion bit in an interrupt status register. It shares that register with a neighbouring data mover, which owns the bit next to it. An interrupt mask and a write-one-to-clear register sit beside the status register. A busy flag can be read through a general status register and is also brought out as a pin.

Top module: `fill_engine`

## Requirements
- R1: After reset, busy, mem_valid and irq are 0. The status register (0x10) reads 0, the mask register (0x0C) reads 0x3, and the offset (0x18), size (0x1C) and pattern (0x20) registers read 0.
- R2: Writing the start register (0x24) with bit 0 set while idle starts a fill. busy reads 1 in the cycle after that write, and the engine issues exactly floor(size/4) memory writes.
- R3: Write k (counting from 0) goes to address (offset with bits 1:0 cleared) + 4k, in ascending order. Its data is the pattern word held when the start register was written. Addresses wrap modulo the memory address width.
- R4: While mem_valid is 1 and mem_ready is 0, mem_valid, mem_addr and mem_data hold steady. Exactly one word completes per cycle in which both are 1.
- R5: When the last word is accepted, busy falls to 0, and status bit 1 at 0x10 (the fill completion bit) becomes 1. General status bit 0 at 0x14 mirrors busy.
- R6: If the size is not a multiple of 4, the leftover bytes are dropped and the engine writes the whole words only.
- R7: A start with size 0 makes no memory write and never raises busy, yet it still sets status bit 1.
- R8: A start write while busy is ignored, and so is a start write whose bit 0 is 0. Neither changes the writes issued or the completion status.
- R9: Writes to the offset, size or pattern registers during a fill do not change that fill. Their new values read back at once.
- R10: irq is 1 whenever some status bit is 1 and its mask bit is 0. The mask register holds bits 1:0, with bit 1 for the fill and bit 0 for the mover.
- R11: A write to the clear register (0x08) clears each status bit whose data bit is 1. Other data bits have no effect, and a set in the same cycle wins over a clear.
- R12: A pulse on mover_done sets status bit 0 and leaves bit 1 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mover_done | input | 1 | Completion pulse from the data mover |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the current write |
| mem_addr | output | MEM_AW | Byte address of the current write |
| mem_data | output | 32 | Data of the current write |
| busy | output | 1 | Fill in progress |
| irq | output | 1 | Unmasked status pending |

## Verification
The fill is tried with the memory always ready and with the memory ready only one cycle in three. This shows that the address steps and the word count depend on accepted handshakes and not on elapsed cycles. The size is tried at a whole number of words, at a value with two leftover bytes and at zero. These three cases tell rounding down and the empty-region path apart from the normal run. A second start and fresh configuration writes issued while a long fill is stalled show whether the working copy is really taken at start time. Mask and clear sequences, together with a mover pulse, show that the two status bits stay independent.

// File: rtl/fill_pkg.sv
// Package: shared register offsets, configuration bundle and sequencer
// state for the pattern fill engine.
package fill_pkg;

    // Register byte offsets
    localparam logic [7:0] OFS_IRQ_CLR  = 8'h08;
    localparam logic [7:0] OFS_IRQ_MASK = 8'h0C;
    localparam logic [7:0] OFS_IRQ_STS  = 8'h10;
    localparam logic [7:0] OFS_GEN_STS  = 8'h14;
    localparam logic [7:0] OFS_OFFSET   = 8'h18;
    localparam logic [7:0] OFS_SIZE     = 8'h1C;
    localparam logic [7:0] OFS_PATTERN  = 8'h20;
    localparam logic [7:0] OFS_START    = 8'h24;

    // Status bit positions
    localparam int STS_MOVER = 0;
    localparam int STS_FILL  = 1;
    localparam int STS_W     = 2;

    typedef struct packed {
        logic [31:0] offset;
        logic [31:0] size;
        logic [31:0] pattern;
    } fill_cfg_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fill_state_e;

endpackage

// File: rtl/fill_regs.sv
// Module: fill_regs
// Register file of the fill engine. It holds the configuration, the
// interrupt status, mask and clear, and the general status, and it
// decodes the start strobe.
// Assumes: single-cycle writes, combinational reads, byte addresses
// with the offsets defined in fill_pkg.
module fill_regs
    import fill_pkg::*;
#(
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic              mover_done_i,
    output fill_cfg_t         cfg_o,
    output logic              start_o,
    output logic              irq_o
);

    localparam logic [STS_W-1:0] MASK_RST = '1;

    fill_cfg_t        cfg_q;
    logic [STS_W-1:0] sts_q;
    logic [STS_W-1:0] mask_q;
    logic [STS_W-1:0] clr_bits;
    logic [STS_W-1:0] set_bits;

    // Decode the register address (the upper address bits are zero-extended)
    function automatic logic hit(input logic [REG_AW-1:0] a, input logic [7:0] ofs);
        return a == REG_AW'(ofs);
    endfunction

    // Start strobe: a write to the start register with bit 0 set
    assign start_o = wr_en && hit(addr, OFS_START) && wdata[0];

    // Clear and set vectors for the status register
    always_comb begin
        clr_bits = '0;
        if (wr_en && hit(addr, OFS_IRQ_CLR)) begin
            clr_bits = wdata[STS_W-1:0];
        end
        set_bits            = '0;
        set_bits[STS_FILL]  = done_i;
        set_bits[STS_MOVER] = mover_done_i;
    end

    // Configuration and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            mask_q <= MASK_RST;
        end else if (wr_en) begin
            if (hit(addr, OFS_OFFSET))   cfg_q.offset  <= wdata;
            if (hit(addr, OFS_SIZE))     cfg_q.size    <= wdata;
            if (hit(addr, OFS_PATTERN))  cfg_q.pattern <= wdata;
            if (hit(addr, OFS_IRQ_MASK)) mask_q        <= wdata[STS_W-1:0];
        end
    end

    // Interrupt status: a set wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= (sts_q & ~clr_bits) | set_bits;
        end
    end

    // Interrupt output from the unmasked status bits
    assign irq_o = |(sts_q & ~mask_q);
    assign cfg_o = cfg_q;

    // Read multiplexer
    always_comb begin
        rdata = '0;
        if (hit(addr, OFS_IRQ_MASK)) rdata = 32'(mask_q);
        if (hit(addr, OFS_IRQ_STS))  rdata = 32'(sts_q);
        if (hit(addr, OFS_GEN_STS))  rdata = {31'b0, busy_i};
        if (hit(addr, OFS_OFFSET))   rdata = cfg_q.offset;
        if (hit(addr, OFS_SIZE))     rdata = cfg_q.size;
        if (hit(addr, OFS_PATTERN))  rdata = cfg_q.pattern;
    end

    // R5: a completion pulse leaves the fill bit set
    a_r5_done_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> sts_q[STS_FILL]);

    // R12: a mover pulse leaves the mover bit set
    a_r12_mover_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        mover_done_i |=> sts_q[STS_MOVER]);

    // R11: the fill bit rises only after a completion pulse
    a_r11_fill_bit_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[STS_FILL]) |-> $past(done_i));

endmodule

// File: rtl/fill_seq.sv
// Module: fill_seq
// Fill sequencer with address generation. On start it takes a working
// copy of the configuration, then writes one word per accepted handshake
// and pulses done after the last word (or at once when there are no
// whole words).
// Assumes: the memory holds addr and data only while valid and ready
// are both 1; start is ignored while busy.
module fill_seq
    import fill_pkg::*;
#(
    parameter int MEM_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  fill_cfg_t         cfg_i,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [31:0]       mem_data,
    output logic              busy_o,
    output logic              done_o
);

    localparam int          CNT_W     = 30;
    localparam logic [MEM_AW-1:0] WORD_STEP = MEM_AW'(4);

    fill_state_e       state_q;
    logic [MEM_AW-1:0] addr_q;
    logic [31:0]       pat_q;
    logic [CNT_W-1:0]  left_q;
    logic              done_q;
    logic [CNT_W-1:0]  start_words;
    logic [MEM_AW-1:0] start_addr;

    // Whole words in the region and the word-aligned first address
    assign start_words = CNT_W'(cfg_i.size >> 2);
    assign start_addr  = MEM_AW'(cfg_i.offset & ~32'd3);

    // Sequencer: takes the working copy, steps per handshake, pulses done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            pat_q   <= '0;
            left_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        addr_q <= start_addr;
                        pat_q  <= cfg_i.pattern;
                        left_q <= start_words;
                        if (start_words == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_ready) begin
                        addr_q <= addr_q + WORD_STEP;
                        left_q <= left_q - 1'b1;
                        if (left_q == CNT_W'(1)) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port drive
    assign mem_valid = (state_q == ST_FILL);
    assign busy_o    = (state_q == ST_FILL);
    assign mem_addr  = addr_q;
    assign mem_data  = pat_q;
    assign done_o    = done_q;

    // R4: a stalled request holds steady
    a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R3: the next request follows at the next word address
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=> (!mem_valid || (mem_addr == $past(mem_addr) + WORD_STEP)));

    // R3: the data stays the same for the whole fill
    a_r3_data_constant: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |=> (!mem_valid || $stable(mem_data)));

    // R5: completion is reported only once the engine is idle
    a_r5_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

// File: rtl/fill_engine.sv
// Module: fill_engine (top)
// Memory pattern fill engine: connects the register file to the fill
// sequencer and brings out the memory write port, busy and irq.
// Assumes: one clock domain with synchronous active-low reset.
module fill_engine
    import fill_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int MEM_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              mover_done,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [31:0]       mem_data,
    output logic              busy,
    output logic              irq
);

    fill_cfg_t cfg;
    logic      start;
    logic      done;

    // Register file
    fill_regs #(.REG_AW(REG_AW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr_en),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .rdata        (reg_rdata),
        .busy_i       (busy),
        .done_i       (done),
        .mover_done_i (mover_done),
        .cfg_o        (cfg),
        .start_o      (start),
        .irq_o        (irq)
    );

    // Fill sequencer
    fill_seq #(.MEM_AW(MEM_AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .cfg_i     (cfg),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .busy_o    (busy),
        .done_o    (done)
    );

    // R2: no memory request while idle
    a_r2_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> busy);

endmodule

// File: tb/fill_engine_tb.sv
// Directed bench for fill_engine: one task per scenario.
module fill_engine_tb;

    localparam int REG_AW = 8;
    localparam int MEM_AW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [REG_AW-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              mover_done = 1'b0;
    logic              mem_valid;
    logic              mem_ready = 1'b1;
    logic [MEM_AW-1:0] mem_addr;
    logic [31:0]       mem_data;
    logic              busy;
    logic              irq;

    int checks = 0;
    int fails = 0;
    int wr_count = 0;
    logic [MEM_AW-1:0] wr_addr [0:63];
    logic [31:0]       wr_data [0:63];
    logic stall_mode = 1'b0;
    int   stall_cnt = 0;

    fill_engine #(.REG_AW(REG_AW), .MEM_AW(MEM_AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mover_done(mover_done),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .busy(busy), .irq(irq)
    );

    always #10 clk = ~clk;

    // Memory model: ready pattern driven away from the edge
    always @(negedge clk) begin
        stall_cnt = stall_cnt + 1;
        mem_ready = stall_mode ? (stall_cnt % 3 == 0) : 1'b1;
    end

    // Memory model: record accepted writes
    always @(posedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            if (wr_count < 64) begin
                wr_addr[wr_count] <= mem_addr;
                wr_data[wr_count] <= mem_data;
            end
            wr_count <= wr_count + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_fill_done(input string req);
        logic [31:0] v;
        bit seen = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            reg_read(8'h10, v);
            if (v[1]) begin seen = 1; break; end
        end
        check(req, 32'(seen), 32'd1);
    endtask

    task automatic clear_status();
        reg_write(8'h08, 32'h20003);
        wr_count = 0;
    endtask

    task automatic check_writes(input string req, input int n,
                                input logic [MEM_AW-1:0] base, input logic [31:0] pat);
        check(req, 32'(wr_count), 32'(n));
        for (int k = 0; k < n && k < 64; k++) begin
            check(req, 32'(wr_addr[k]), 32'(base + MEM_AW'(4 * k)));
            check(req, wr_data[k], pat);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        check("R1 busy", 32'(busy), 0);
        check("R1 valid", 32'(mem_valid), 0);
        check("R1 irq", 32'(irq), 0);
        reg_read(8'h10, v); check("R1 status", v, 0);
        reg_read(8'h0C, v); check("R1 mask", v, 32'h3);
        reg_read(8'h18, v); check("R1 offset", v, 0);
        reg_read(8'h1C, v); check("R1 size", v, 0);
        reg_read(8'h20, v); check("R1 pattern", v, 0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        stall_mode = 1'b0;
        clear_status();
        reg_write(8'h18, 32'h100);
        reg_write(8'h1C, 32'd16);
        reg_write(8'h20, 32'h4D4D434F);
        reg_write(8'h24, 32'h1);
        check("R2 busy after start", 32'(busy), 1);
        reg_read(8'h14, v); check("R5 gen status busy", v, 1);
        wait_fill_done("R5 completion");
        check("R5 busy cleared", 32'(busy), 0);
        reg_read(8'h14, v); check("R5 gen status idle", v, 0);
        check_writes("R3 basic fill", 4, 16'h100, 32'h4D4D434F);
    endtask

    task automatic t_stall();
        stall_mode = 1'b1;
        clear_status();
        reg_write(8'h18, 32'h2F2);   // unaligned, rounds down to 0x2F0
        reg_write(8'h1C, 32'd20);
        reg_write(8'h20, 32'h0BADF00D);
        reg_write(8'h24, 32'h1);
        wait_fill_done("R4 stalled completion");
        check_writes("R4 stalled fill", 5, 16'h2F0, 32'h0BADF00D);
        stall_mode = 1'b0;
    endtask

    task automatic t_round();
        clear_status();
        reg_write(8'h18, 32'h40);
        reg_write(8'h1C, 32'd10);
        reg_write(8'h20, 32'h11223344);
        reg_write(8'h24, 32'h1);
        wait_fill_done("R6 completion");
        check_writes("R6 rounded size", 2, 16'h40, 32'h11223344);
    endtask

    task automatic t_zero();
        clear_status();
        reg_write(8'h1C, 32'd3);     // fewer than one word
        reg_write(8'h24, 32'h1);
        check("R7 never busy", 32'(busy), 0);
        wait_fill_done("R7 status set");
        check("R7 no writes", 32'(wr_count), 0);
        clear_status();
        reg_write(8'h1C, 32'd0);
        reg_write(8'h24, 32'h1);
        check("R7 never busy size 0", 32'(busy), 0);
        wait_fill_done("R7 status set size 0");
        check("R7 no writes size 0", 32'(wr_count), 0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        stall_mode = 1'b1;
        clear_status();
        reg_write(8'h18, 32'h800);
        reg_write(8'h1C, 32'd40);
        reg_write(8'h20, 32'hCAFEBABE);
        reg_write(8'h24, 32'h1);
        reg_write(8'h1C, 32'd8);
        reg_write(8'h20, 32'hA5A5A5A5);
        reg_write(8'h18, 32'h900);
        reg_write(8'h24, 32'h1);
        reg_read(8'h1C, v); check("R9 size readback", v, 32'd8);
        reg_read(8'h20, v); check("R9 pattern readback", v, 32'hA5A5A5A5);
        wait_fill_done("R8 completion");
        repeat (4) @(negedge clk);
        check_writes("R8 R9 fill unchanged", 10, 16'h800, 32'hCAFEBABE);
        stall_mode = 1'b0;
        clear_status();
        reg_write(8'h24, 32'h2);     // bit 0 clear: no start
        check("R8 bit0 clear not busy", 32'(busy), 0);
        repeat (4) @(negedge clk);
        reg_read(8'h10, v); check("R8 bit0 clear no status", v, 0);
        check("R8 bit0 clear no writes", 32'(wr_count), 0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        clear_status();
        reg_write(8'h1C, 32'd4);
        reg_write(8'h24, 32'h1);
        wait_fill_done("R10 completion");
        check("R10 masked irq", 32'(irq), 0);
        reg_write(8'h0C, 32'h0);
        check("R10 unmasked irq", 32'(irq), 1);
        reg_write(8'h0C, 32'h1);
        check("R10 fill bit unmasked", 32'(irq), 1);
        reg_write(8'h08, 32'hFFFFFFFC);  // bits 1:0 zero: nothing cleared
        reg_read(8'h10, v); check("R11 no clear", v, 32'h2);
        reg_write(8'h08, 32'h2);
        reg_read(8'h10, v); check("R11 cleared", v, 0);
        check("R11 irq low", 32'(irq), 0);
        reg_write(8'h0C, 32'h0);
    endtask

    task automatic t_mover();
        logic [31:0] v;
        @(negedge clk);
        mover_done = 1'b1;
        @(negedge clk);
        mover_done = 1'b0;
        reg_read(8'h10, v); check("R12 mover bit only", v, 32'h1);
        check("R12 irq from mover", 32'(irq), 1);
        reg_write(8'h08, 32'h1);
        reg_read(8'h10, v); check("R12 mover cleared", v, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_stall();
        t_round();
        t_zero();
        t_busy_ignore();
        t_irq();
        t_mover();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule